// File: doc/BRIEF.md
# USART Bit-Rate Clock Generator

This block turns the system clock into all the bit timing a USART needs. A 12-bit down-counting prescaler reloads from a programmable divider value S and expires once every S+1 system clocks. Every other timing signal is derived from that expiry. In asynchronous operation each expiry is one receiver sample, and a transmit bit tick follows every sixteenth sample (normal rate) or every eighth (double rate). In synchronous master operation each expiry toggles a clock pin that the block drives. In synchronous slave operation the block tracks an external clock on that pin through a synchronizer and an edge detector.

In every mode the block gives two one-cycle enables: one for the cycle in which transmit data should change, and one for the cycle in which receive data should be sampled. In synchronous modes these fall on opposite edges of the serial clock, and a polarity input picks which edge is which. All pins are plain control and timing signals. There is no data stream and no handshake.

Top module: `usart_clkgen`

## Requirements
- R1: During and right after reset, tx_tick, rx_tick, rx_mid, xck_out and xck_oe are 0 and rx_sample_idx is 0. The prescaler resets to its maximum count, 4095.
- R2: When div_set holds S, prescaler expiries are exactly S+1 system clocks apart. In asynchronous mode each expiry gives one rx_tick.
- R3: In normal asynchronous mode (sync_mode=0, dbl_speed=0), successive rx_ticks report rx_sample_idx 0,1,...,15 and then wrap. tx_tick is high only together with the rx_tick that carries index 15, so the bit rate is fclk/(16(S+1)).
- R4: In double-speed asynchronous mode (sync_mode=0, dbl_speed=1), the index runs 0..7 and tx_tick comes with index 7, so the bit rate is fclk/(8(S+1)).
- R5: rx_mid is high only on an rx_tick whose index is one of the three middle samples: 7, 8 or 9 in normal mode, and 3, 4 or 5 in double-speed mode.
- R6: A cycle with div_wr=1 loads div_set into the prescaler and clears the sample index. No tick appears in that cycle. The next expiry comes S+1 cycles later and carries index 0.
- R7: In synchronous master mode (sync_mode=1, master=1), xck_oe is 1. xck_out toggles on the clock edge after each expiry, so its period is 2(S+1) system clocks. dbl_speed has no effect.
- R8: In synchronous modes, tx_tick and rx_tick never coincide. With edge_pol=0, tx_tick marks a rising edge of the serial clock and rx_tick marks a falling edge. With edge_pol=1 the two are swapped.
- R9: In synchronous slave mode (sync_mode=1, master=0), xck_oe is 0. A level change on xck_in produces exactly one tick, one cycle wide, in the cycle after the first clock edge that samples the new level. That is a two-clock delay to the edge where the tick is used. The external clock must stay below fclk/4.
- R10: In synchronous modes, rx_sample_idx stays 0 and rx_mid stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_mode | input | 1 | 1 = synchronous operation, 0 = asynchronous |
| master | input | 1 | In synchronous mode, 1 = drive the serial clock, 0 = follow it |
| dbl_speed | input | 1 | Asynchronous double rate (8 samples per bit) |
| edge_pol | input | 1 | 0 = transmit on rising serial-clock edge, 1 = on falling edge |
| div_set | input | 12 | Divider value S |
| div_wr | input | 1 | Load strobe for div_set |
| xck_in | input | 1 | External serial clock (slave) |
| xck_out | output | 1 | Generated serial clock (master) |
| xck_oe | output | 1 | Output enable for the serial clock pin |
| tx_tick | output | 1 | Transmit-data change enable |
| rx_tick | output | 1 | Receive sample enable |
| rx_sample_idx | output | 4 | Index of the current sample within the bit |
| rx_mid | output | 1 | Current sample is one of the middle three |

## Verification
A table of configurations runs normal and double-speed asynchronous modes with several divider values, including S=0. This tells apart the two sample counts, shows the middle-sample window moving with the mode, and catches any off-by-one in the reload period. Master configurations with both polarities, one of them with dbl_speed set, show that toggling ignores the rate doubling and that the polarity swaps the transmit and receive edges. Directed slave tests move xck_in in both directions under both polarities and check the exact cycle in which the single tick appears.

// File: rtl/usart_clk_pkg.sv
package usart_clk_pkg;

  typedef enum logic [1:0] {
    CM_ASYNC_NORM,
    CM_ASYNC_DBL,
    CM_SYNC_MASTER,
    CM_SYNC_SLAVE
  } clk_mode_e;

  function automatic clk_mode_e decode_mode(input logic sync_mode,
                                            input logic master,
                                            input logic dbl);
    if (sync_mode) return master ? CM_SYNC_MASTER : CM_SYNC_SLAVE;
    return dbl ? CM_ASYNC_DBL : CM_ASYNC_NORM;
  endfunction

endpackage

// File: rtl/usart_prescaler.sv
module usart_prescaler #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] reload_val,
  input  logic             reload,
  output logic             expire
);

  logic [DIV_W-1:0] cnt_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign expire  = at_zero && !reload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '1;
    else if (reload || at_zero)  cnt_q <= reload_val;
    else                         cnt_q <= cnt_q - 1'b1;
  end

endmodule

// File: rtl/usart_sample_ctr.sv
module usart_sample_ctr #(
  parameter int OVS_NORM = 16,
  parameter int OVS_DBL  = 8,
  localparam int IDX_W   = $clog2(OVS_NORM)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             dbl,
  input  logic             step,
  input  logic             clear,
  output logic [IDX_W-1:0] idx,
  output logic             rx_tick,
  output logic             tx_tick,
  output logic             mid
);

  localparam logic [IDX_W-1:0] LAST_NORM = IDX_W'(OVS_NORM - 1);
  localparam logic [IDX_W-1:0] LAST_DBL  = IDX_W'(OVS_DBL - 1);
  localparam logic [IDX_W-1:0] CTR_NORM  = IDX_W'(OVS_NORM / 2);
  localparam logic [IDX_W-1:0] CTR_DBL   = IDX_W'(OVS_DBL / 2);

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] last;
  logic [IDX_W-1:0] ctr;
  logic             wrap;

  assign last    = dbl ? LAST_DBL : LAST_NORM;
  assign ctr     = dbl ? CTR_DBL  : CTR_NORM;
  assign wrap    = (idx_q >= last);
  assign rx_tick = step && enable;
  assign tx_tick = rx_tick && wrap;
  assign mid     = rx_tick && (idx_q == ctr - 1'b1 || idx_q == ctr ||
                               idx_q == ctr + 1'b1);
  assign idx     = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              idx_q <= '0;
    else if (clear || !enable) idx_q <= '0;
    else if (step)           idx_q <= wrap ? '0 : idx_q + 1'b1;
  end

endmodule

// File: rtl/usart_sync_clk.sv
module usart_sync_clk (
  input  logic clk,
  input  logic rst_n,
  input  logic master_en,
  input  logic step,
  input  logic ext_clk,
  output logic clk_out,
  output logic rise,
  output logic fall
);

  logic drv_q;
  logic smp_q;
  logic dly_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q <= 1'b0;
      smp_q <= 1'b0;
      dly_q <= 1'b0;
    end else begin
      smp_q <= ext_clk;
      dly_q <= smp_q;
      if (!master_en) drv_q <= 1'b0;
      else if (step)  drv_q <= ~drv_q;
    end
  end

  assign clk_out = drv_q;
  assign rise = master_en ? (step && !drv_q) : (smp_q && !dly_q);
  assign fall = master_en ? (step && drv_q)  : (!smp_q && dly_q);

endmodule

// File: rtl/usart_clkgen.sv
module usart_clkgen
  import usart_clk_pkg::*;
#(
  parameter int DIV_W    = 12,
  parameter int OVS_NORM = 16,
  parameter int OVS_DBL  = 8,
  localparam int IDX_W   = $clog2(OVS_NORM)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_mode,
  input  logic             master,
  input  logic             dbl_speed,
  input  logic             edge_pol,
  input  logic [DIV_W-1:0] div_set,
  input  logic             div_wr,
  input  logic             xck_in,
  output logic             xck_out,
  output logic             xck_oe,
  output logic             tx_tick,
  output logic             rx_tick,
  output logic [IDX_W-1:0] rx_sample_idx,
  output logic             rx_mid
);

  clk_mode_e mode;
  logic async_en, master_en, sync_en;
  logic expire;
  logic a_rx, a_tx, a_mid;
  logic s_rise, s_fall;

  assign mode      = decode_mode(sync_mode, master, dbl_speed);
  assign async_en  = (mode == CM_ASYNC_NORM) || (mode == CM_ASYNC_DBL);
  assign master_en = (mode == CM_SYNC_MASTER);
  assign sync_en   = !async_en;

  usart_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk        (clk),
    .rst_n      (rst_n),
    .reload_val (div_set),
    .reload     (div_wr),
    .expire     (expire)
  );

  usart_sample_ctr #(.OVS_NORM(OVS_NORM), .OVS_DBL(OVS_DBL)) u_samp (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (async_en),
    .dbl     (mode == CM_ASYNC_DBL),
    .step    (expire),
    .clear   (div_wr),
    .idx     (rx_sample_idx),
    .rx_tick (a_rx),
    .tx_tick (a_tx),
    .mid     (a_mid)
  );

  usart_sync_clk u_sclk (
    .clk       (clk),
    .rst_n     (rst_n),
    .master_en (master_en),
    .step      (expire),
    .ext_clk   (xck_in),
    .clk_out   (xck_out),
    .rise      (s_rise),
    .fall      (s_fall)
  );

  always_comb begin
    if (sync_en) begin
      tx_tick = edge_pol ? s_fall : s_rise;
      rx_tick = edge_pol ? s_rise : s_fall;
    end else begin
      tx_tick = a_tx;
      rx_tick = a_rx;
    end
  end

  assign rx_mid = a_mid;
  assign xck_oe = master_en;

endmodule

// File: rtl/usart_clkgen_chk.sv
module usart_clkgen_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_mode,
  input logic             master,
  input logic             div_wr,
  input logic             xck_in,
  input logic             xck_out,
  input logic             tx_tick,
  input logic             rx_tick,
  input logic [IDX_W-1:0] rx_sample_idx,
  input logic             rx_mid
);

  assert_tx_rx_apart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sync_mode |-> !(tx_tick && rx_tick));

  assert_bit_on_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_mode && tx_tick) |-> rx_tick);

  assert_mid_needs_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_mid |-> rx_tick);

  assert_idx_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_mode && rx_tick && !tx_tick && !div_wr) |=>
      (div_wr || sync_mode || rx_sample_idx == $past(rx_sample_idx) + 1'b1));

  assert_master_toggles_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && master && (tx_tick || rx_tick)) |=> (xck_out != $past(xck_out)));

  assert_slave_follows_pin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && !master && (tx_tick || rx_tick)) |->
      ($past(xck_in) != $past(xck_in, 2)));

endmodule

bind usart_clkgen usart_clkgen_chk #(.IDX_W(IDX_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sync_mode     (sync_mode),
  .master        (master),
  .div_wr        (div_wr),
  .xck_in        (xck_in),
  .xck_out       (xck_out),
  .tx_tick       (tx_tick),
  .rx_tick       (rx_tick),
  .rx_sample_idx (rx_sample_idx),
  .rx_mid        (rx_mid)
);

// File: tb/sim_usart_clkgen.sv
module sim_usart_clkgen;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_mode = 1'b0, master = 1'b0, dbl_speed = 1'b0, edge_pol = 1'b0;
  logic [11:0] div_set = '0;
  logic div_wr = 1'b0;
  logic xck_in = 1'b0;
  logic xck_out, xck_oe, tx_tick, rx_tick, rx_mid;
  logic [3:0] rx_sample_idx;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  usart_clkgen u0 (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .master(master),
    .dbl_speed(dbl_speed), .edge_pol(edge_pol), .div_set(div_set),
    .div_wr(div_wr), .xck_in(xck_in), .xck_out(xck_out), .xck_oe(xck_oe),
    .tx_tick(tx_tick), .rx_tick(rx_tick), .rx_sample_idx(rx_sample_idx),
    .rx_mid(rx_mid)
  );

  // {sync, master, dbl, pol, div[11:0], expected samples per bit (0 = sync)}
  localparam logic [20:0] VEC [6] = '{
    {4'b0000, 12'd3, 5'd16},
    {4'b0010, 12'd2, 5'd8},
    {4'b0000, 12'd0, 5'd16},
    {4'b0010, 12'd0, 5'd8},
    {4'b1100, 12'd4, 5'd0},
    {4'b1111, 12'd1, 5'd0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic write_cfg(input logic s, input logic m, input logic d,
                           input logic p, input logic [11:0] dv);
    @(negedge clk);
    sync_mode = s; master = m; dbl_speed = d; edge_pol = p;
    div_set = dv; div_wr = 1'b1;
    #1;
    if (!s) chk(!tx_tick && !rx_tick, "R6 no tick in write cycle",
                int'(tx_tick || rx_tick), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!tx_tick && !rx_tick && !rx_mid, "R1 ticks in reset", int'(tx_tick|rx_tick|rx_mid), 0);
    chk(rx_sample_idx == 0, "R1 index in reset", rx_sample_idx, 0);
    chk(!xck_out && !xck_oe, "R1 clock pin in reset", int'({xck_out, xck_oe}), 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!tx_tick && !rx_tick, "R1 ticks after reset", int'(tx_tick|rx_tick), 0);

    for (int v = 0; v < 6; v++) begin
      automatic logic        vs   = VEC[v][20];
      automatic logic        vm   = VEC[v][19];
      automatic logic        vd   = VEC[v][18];
      automatic logic        vp   = VEC[v][17];
      automatic int          per  = int'(VEC[v][16:5]) + 1;
      automatic int          ovs  = int'(VEC[v][4:0]);
      automatic int          win  = (ovs != 0) ? 2 * ovs * per : 8 * per;
      automatic logic        xexp = 1'b0;
      write_cfg(vs, vm, vd, vp, VEC[v][16:5]);
      for (int c = 1; c <= win; c++) begin
        automatic bit ev = (c % per) == 0;
        @(negedge clk);
        div_wr = 1'b0;
        #1;
        if (ovs != 0) begin
          chk(rx_tick == ev, "R2 sample spacing", rx_tick, ev);
          if (ev) begin
            automatic int k  = c / per - 1;
            automatic int ei = k % ovs;
            automatic bit em = (ei >= ovs / 2 - 1) && (ei <= ovs / 2 + 1);
            if (k == 0) chk(rx_sample_idx == 0, "R6 index after load", rx_sample_idx, 0);
            chk(rx_sample_idx == ei, (ovs == 16) ? "R3 index" : "R4 index", rx_sample_idx, ei);
            chk(tx_tick == (ei == ovs - 1), (ovs == 16) ? "R3 bit tick" : "R4 bit tick",
                tx_tick, int'(ei == ovs - 1));
            chk(rx_mid == em, "R5 middle flag", rx_mid, em);
          end else begin
            chk(!tx_tick && !rx_mid, "R2 quiet between samples", int'(tx_tick|rx_mid), 0);
          end
        end else begin
          if (c == 1) xexp = xck_out;
          chk(xck_oe, "R7 pin driven", xck_oe, 1);
          chk(xck_out == xexp, "R7 clock level", xck_out, xexp);
          chk(rx_sample_idx == 0 && !rx_mid, "R10 sync index", rx_sample_idx, 0);
          if (ev) begin
            chk(tx_tick == (xexp == vp), "R8 tx edge", tx_tick, int'(xexp == vp));
            chk(rx_tick == (xexp != vp), "R8 rx edge", rx_tick, int'(xexp != vp));
            xexp = ~xexp;
          end else begin
            chk(!tx_tick && !rx_tick, "R7 no tick between toggles", int'(tx_tick|rx_tick), 0);
          end
        end
      end
    end

    // Slave mode, edge_pol = 0
    write_cfg(1'b1, 1'b0, 1'b0, 1'b0, 12'd5);
    @(negedge clk); div_wr = 1'b0; #1;
    chk(!xck_oe, "R9 pin released", xck_oe, 0);
    @(negedge clk); xck_in = 1'b1; #1;
    chk(!tx_tick && !rx_tick, "R9 no tick before sampling", int'(tx_tick|rx_tick), 0);
    @(negedge clk); #1;
    chk(tx_tick && !rx_tick, "R8 slave rise gives tx", int'({tx_tick, rx_tick}), 2);
    chk(rx_sample_idx == 0 && !rx_mid, "R10 slave index", rx_sample_idx, 0);
    @(negedge clk); #1;
    chk(!tx_tick && !rx_tick, "R9 single-cycle tick", int'(tx_tick|rx_tick), 0);
    @(negedge clk); #1;
    chk(!tx_tick && !rx_tick, "R9 steady pin quiet", int'(tx_tick|rx_tick), 0);
    xck_in = 1'b0;
    @(negedge clk); #1;
    chk(rx_tick && !tx_tick, "R9 slave fall gives rx", int'({tx_tick, rx_tick}), 1);
    @(negedge clk); #1;
    chk(!rx_tick, "R9 fall tick one cycle", rx_tick, 0);

    // Slave mode, edge_pol = 1
    edge_pol = 1'b1; xck_in = 1'b1;
    @(negedge clk); #1;
    chk(rx_tick && !tx_tick, "R8 swapped rise gives rx", int'({tx_tick, rx_tick}), 1);
    xck_in = 1'b0;
    @(negedge clk); @(negedge clk); #1;
    chk(!tx_tick && !rx_tick, "R9 ends after one cycle", int'(tx_tick|rx_tick), 0);

    report();
  end

endmodule